// File: doc/BRIEF.md
# Dual-Channel Frame Status FIFO

This block keeps end-of-frame records for a two-channel synchronous serial receiver that runs bit-oriented framing. Each time a frame closes, the receiver presents one record for that channel: a byte count and a set of status bits. The block stores the record until the CPU collects it. A CPU that answers interrupts late can therefore still recover the status of several frames that arrived back to back.

The CPU reads each channel through two registers. The upper register shows the upper part of the oldest record together with a valid flag and an overflow flag. Reading the lower register takes the record out of the queue. Each channel has an enable bit. The two enable bits interact: enabling only channel A turns both queues on as a linked pair. When a channel's queue is not in service, the same read addresses return the receiver's live status directly.

Top module: `frame_status_fifo`

## Requirements
- R1: Each channel holds up to 10 records and returns them oldest first. A record is 19 bits wide: the byte count sits in bits 13:0 and the status bits sit in bits 18:14.
- R2: While a channel is in service, the upper read (`rd_lo`=0) returns {valid at bit 15, overflow at bit 14, zeros at bits 13:11, record bits 18:8 at bits 10:0}. The lower read (`rd_lo`=1) returns {eight zeros, record bits 7:0}. An empty queue shows valid=0 and zero record bits.
- R3: A lower read with `rd_stb`=1 removes the oldest record. The same read on an empty queue changes nothing.
- R4: A push into a full queue is dropped, and the push sets a sticky overflow flag. That flag is cleared only by a reset of that queue.
- R5: A push and a removal in the same cycle on a non-empty queue both take effect, and the occupancy stays the same.
- R6: A channel is in service only while its effective enable is 1 and its frame-mode input is 1. While the channel is enabled but the frame-mode input is 0, pushes are ignored and the stored records are kept.
- R7: While a channel is out of service, the upper read returns {five zeros, live bits 18:8} and the lower read returns {eight zeros, live bits 7:0}. A lower read with `rd_stb`=1 removes nothing.
- R8: The effective enables follow the table A only = both on, A and B = both on, B only = B only, neither = both off. `en_rb` bit 0 reports A's effective enable and bit 1 reports B's.
- R9: A queue whose effective enable is 0 is held empty with its overflow flag clear. Clearing `en_b` empties queue B only, and B stays enabled if `en_a` is 1. Clearing `en_a` empties A, and it also empties B when `en_b` is 0.
- R10: An active-low reset empties both queues and clears both overflow flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_a | input | 1 | Channel A enable bit |
| en_b | input | 1 | Channel B enable bit |
| mode_a | input | 1 | Channel A is in bit-oriented frame mode |
| mode_b | input | 1 | Channel B is in bit-oriented frame mode |
| push_a | input | 1 | End-of-frame strobe for channel A |
| cnt_a | input | 14 | Byte count of the frame ending on A |
| stat_a | input | 5 | Status bits of the frame ending on A |
| push_b | input | 1 | End-of-frame strobe for channel B |
| cnt_b | input | 14 | Byte count of the frame ending on B |
| stat_b | input | 5 | Status bits of the frame ending on B |
| live_a | input | 19 | Live status word of receiver A |
| live_b | input | 19 | Live status word of receiver B |
| rd_ch | input | 1 | Channel that is read (0=A, 1=B) |
| rd_lo | input | 1 | 0 selects the upper read register, 1 selects the lower one |
| rd_stb | input | 1 | Read access strobe; with `rd_lo`=1 it removes a record |
| rd_data | output | 16 | Read data for the selected channel and half |
| en_rb | output | 2 | Effective enable readback {B, A} |

## Verification
The assertions assume that the enable, frame-mode, push and read inputs are stable between rising edges. They also assume that a read strobe lasts exactly one cycle for each record to be removed. The bench meets both assumptions because it changes every input just after a falling edge and holds each strobe for one full cycle. The bench also changes an enable bit only when no push or read is pending on that channel. This keeps each scenario's expected queue contents unambiguous.

// File: rtl/frame_status_fifo.sv
module frame_status_fifo #(
  parameter int DEPTH  = 10,
  parameter int CNT_W  = 14,
  parameter int STAT_W = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en_a,
  input  logic                      en_b,
  input  logic                      mode_a,
  input  logic                      mode_b,
  input  logic                      push_a,
  input  logic [CNT_W-1:0]          cnt_a,
  input  logic [STAT_W-1:0]         stat_a,
  input  logic                      push_b,
  input  logic [CNT_W-1:0]          cnt_b,
  input  logic [STAT_W-1:0]         stat_b,
  input  logic [CNT_W+STAT_W-1:0]   live_a,
  input  logic [CNT_W+STAT_W-1:0]   live_b,
  input  logic                      rd_ch,
  input  logic                      rd_lo,
  input  logic                      rd_stb,
  output logic [CNT_W+STAT_W-4:0]   rd_data,
  output logic [1:0]                en_rb
);
  localparam int ENT_W = CNT_W + STAT_W;
  localparam int HI_W  = ENT_W - 8;
  localparam int RD_W  = HI_W + 5;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [1:0] en_raw, eff, mode, push, active, has_data, ovf_w;
  logic [ENT_W-1:0] din  [2];
  logic [ENT_W-1:0] live [2];
  logic [ENT_W-1:0] head [2];
  logic [OCC_W-1:0] occ_w [2];
  logic [OCC_W-1:0] occ_a_mon, occ_b_mon;
  logic ovf_a_mon;

  assign en_raw  = {en_b, en_a};
  assign eff     = {en_a | en_b, en_a};
  assign mode    = {mode_b, mode_a};
  assign push    = {push_b, push_a};
  assign active  = eff & mode;
  assign din[0]  = {stat_a, cnt_a};
  assign din[1]  = {stat_b, cnt_b};
  assign live[0] = live_a;
  assign live[1] = live_b;
  assign en_rb   = eff;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [ENT_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [OCC_W-1:0] occ;
    logic ovf_r, en_q, clr, full, do_push, do_pop;

    assign clr     = ~eff[c] | (en_q & ~en_raw[c]);
    assign full    = (occ == OCC_W'(DEPTH));
    assign do_pop  = rd_stb & rd_lo & (rd_ch == 1'(c)) & active[c] & (occ != '0) & ~clr;
    assign do_push = push[c] & active[c] & ~clr & (~full | do_pop);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp    <= '0;
        rp    <= '0;
        occ   <= '0;
        ovf_r <= 1'b0;
        en_q  <= 1'b0;
      end else begin
        en_q <= en_raw[c];
        if (clr) begin
          wp    <= '0;
          rp    <= '0;
          occ   <= '0;
          ovf_r <= 1'b0;
        end else begin
          if (do_push) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
          if (do_pop)  rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
          if (do_push && !do_pop)      occ <= occ + 1'b1;
          else if (do_pop && !do_push) occ <= occ - 1'b1;
          if (push[c] && active[c] && full && !do_pop) ovf_r <= 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din[c];
    end

    assign has_data[c] = (occ != '0);
    assign head[c]     = has_data[c] ? mem[rp] : '0;
    assign occ_w[c]    = occ;
    assign ovf_w[c]    = ovf_r;
  end

  logic [ENT_W-1:0] word;
  logic [1:0]       flags;

  assign word    = active[rd_ch] ? head[rd_ch] : live[rd_ch];
  assign flags   = active[rd_ch] ? {has_data[rd_ch], ovf_w[rd_ch]} : 2'b00;
  assign rd_data = rd_lo ? {{(RD_W-8){1'b0}}, word[7:0]}
                         : {flags, 3'b000, word[ENT_W-1:8]};

  assign occ_a_mon = occ_w[0];
  assign occ_b_mon = occ_w[1];
  assign ovf_a_mon = ovf_w[0];
endmodule

module frame_status_fifo_chk #(
  parameter int DEPTH = 10,
  parameter int ENT_W = 19,
  parameter int OCC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_a,
  input logic             en_b,
  input logic             mode_a,
  input logic             push_a,
  input logic             rd_ch,
  input logic             rd_lo,
  input logic             rd_stb,
  input logic [ENT_W-4:0] rd_data,
  input logic [ENT_W-9:0] live_hi,
  input logic [1:0]       en_rb,
  input logic [OCC_W-1:0] occ_a,
  input logic [OCC_W-1:0] occ_b,
  input logic             ovf_a
);
  assert_occ_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_a <= OCC_W'(DEPTH)) && (occ_b <= OCC_W'(DEPTH)));

  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_a && en_a) |=> ovf_a);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_a == OCC_W'(DEPTH) && push_a && en_a && mode_a && !(rd_stb && rd_lo && !rd_ch))
    |=> (ovf_a && occ_a == OCC_W'(DEPTH)));

  assert_push_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_a != '0 && push_a && en_a && mode_a && rd_stb && rd_lo && !rd_ch) |=> $stable(occ_a));

  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a && !mode_a) |=> $stable(occ_a));

  assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_ch && !rd_lo && !(en_a && mode_a)) |-> (rd_data == {5'b00000, live_hi}));

  assert_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en_a |-> (en_rb == 2'b11));

  assert_off_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_a |=> (occ_a == '0 && !ovf_a));

  assert_off_empty_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_a || en_b) |=> (occ_b == '0));
endmodule

bind frame_status_fifo frame_status_fifo_chk #(
  .DEPTH(DEPTH), .ENT_W(ENT_W), .OCC_W(OCC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en_a(en_a), .en_b(en_b), .mode_a(mode_a),
  .push_a(push_a), .rd_ch(rd_ch), .rd_lo(rd_lo), .rd_stb(rd_stb),
  .rd_data(rd_data), .live_hi(live_a[ENT_W-1:8]), .en_rb(en_rb),
  .occ_a(occ_a_mon), .occ_b(occ_b_mon), .ovf_a(ovf_a_mon)
);

// File: tb/frame_status_fifo_tb.sv
module frame_status_fifo_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_a = 0, en_b = 0, mode_a = 0, mode_b = 0;
  logic push_a = 0, push_b = 0;
  logic [13:0] cnt_a = '0, cnt_b = '0;
  logic [4:0]  stat_a = '0, stat_b = '0;
  logic [18:0] live_a = 19'h5A5A5, live_b = 19'h31C3C;
  logic rd_ch = 0, rd_lo = 0, rd_stb = 0;
  logic [15:0] rd_data;
  logic [1:0]  en_rb;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  frame_status_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .en_a(en_a), .en_b(en_b), .mode_a(mode_a), .mode_b(mode_b),
    .push_a(push_a), .cnt_a(cnt_a), .stat_a(stat_a),
    .push_b(push_b), .cnt_b(cnt_b), .stat_b(stat_b),
    .live_a(live_a), .live_b(live_b), .rd_ch(rd_ch), .rd_lo(rd_lo), .rd_stb(rd_stb),
    .rd_data(rd_data), .en_rb(en_rb)
  );

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] hi_of(logic v, logic o, logic [18:0] e);
    return {v, o, 3'b000, e[18:8]};
  endfunction

  function automatic logic [15:0] lo_of(logic [18:0] e);
    return {8'h00, e[7:0]};
  endfunction

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic push(input logic ch, input logic [18:0] e);
    if (ch) begin push_b = 1; {stat_b, cnt_b} = e; end
    else    begin push_a = 1; {stat_a, cnt_a} = e; end
    tick;
    push_a = 0; push_b = 0;
  endtask

  task automatic rd(input logic ch, input logic lo, input logic stb, output logic [15:0] d);
    rd_ch = ch; rd_lo = lo; rd_stb = stb;
    #1 d = rd_data;
    tick;
    rd_stb = 0;
  endtask

  task automatic expect_entry(string tag, logic ch, logic [18:0] e, logic ovf);
    logic [15:0] d;
    rd(ch, 1'b0, 1'b0, d); check({tag, " hi"}, d, hi_of(1'b1, ovf, e));
    rd(ch, 1'b1, 1'b1, d); check({tag, " lo"}, d, lo_of(e));
  endtask

  task automatic expect_empty(string tag, logic ch, logic ovf);
    logic [15:0] d;
    rd(ch, 1'b0, 1'b0, d); check(tag, d, {1'b0, ovf, 14'h0000});
  endtask

  task automatic t_reset;
    logic [15:0] d;
    check("R8 en_rb after reset", {14'h0, en_rb}, 16'h0000);
    rd(1'b0, 1'b0, 1'b0, d); check("R10/R7 A upper bypass", d, {5'b0, live_a[18:8]});
    rd(1'b1, 1'b1, 1'b1, d); check("R7 B lower bypass", d, lo_of(live_b));
  endtask

  task automatic t_order;
    logic [15:0] d;
    en_a = 1; mode_a = 1; tick;
    expect_empty("R2 empty valid=0", 1'b0, 1'b0);
    push(1'b0, 19'h4A123); push(1'b0, 19'h1BEEF); push(1'b0, 19'h70001);
    expect_entry("R1 order e0", 1'b0, 19'h4A123, 1'b0);
    expect_entry("R1 order e1", 1'b0, 19'h1BEEF, 1'b0);
    expect_entry("R1 order e2", 1'b0, 19'h70001, 1'b0);
    rd(1'b0, 1'b1, 1'b1, d); check("R3 pop on empty data", d, 16'h0000);
    push(1'b0, 19'h2C0DE);
    expect_entry("R3 pop on empty no effect", 1'b0, 19'h2C0DE, 1'b0);
    expect_empty("R2 drained", 1'b0, 1'b0);
  endtask

  task automatic t_full;
    for (int i = 0; i < 10; i++) push(1'b0, 19'((i * 19'h0A31) + 19'h00105));
    push(1'b0, 19'h7FFFF);
    for (int i = 0; i < 10; i++)
      expect_entry($sformatf("R4 full entry %0d", i), 1'b0, 19'((i * 19'h0A31) + 19'h00105), 1'b1);
    expect_empty("R4 overflow sticky after drain", 1'b0, 1'b1);
    en_a = 0; tick; en_a = 1; tick;
    expect_empty("R9 disable clears overflow", 1'b0, 1'b0);
  endtask

  task automatic t_simul;
    logic [15:0] d;
    push(1'b0, 19'h11111); push(1'b0, 19'h22222);
    push_a = 1; {stat_a, cnt_a} = 19'h33333;
    rd_ch = 0; rd_lo = 1; rd_stb = 1;
    #1 d = rd_data;
    check("R5 pop data same cycle", d, lo_of(19'h11111));
    tick;
    push_a = 0; rd_stb = 0;
    expect_entry("R5 after push+pop e1", 1'b0, 19'h22222, 1'b0);
    expect_entry("R5 after push+pop e2", 1'b0, 19'h33333, 1'b0);
    expect_empty("R5 count kept", 1'b0, 1'b0);
  endtask

  task automatic t_mode;
    logic [15:0] d;
    push(1'b0, 19'h0ABCD);
    mode_a = 0; tick;
    push(1'b0, 19'h55555);
    rd(1'b0, 1'b0, 1'b0, d); check("R6/R7 mode off upper bypass", d, {5'b0, live_a[18:8]});
    rd(1'b0, 1'b1, 1'b1, d); check("R7 mode off lower bypass", d, lo_of(live_a));
    mode_a = 1; tick;
    expect_entry("R6 contents kept", 1'b0, 19'h0ABCD, 1'b0);
    expect_empty("R6 push ignored", 1'b0, 1'b0);
  endtask

  task automatic t_link;
    logic [15:0] d;
    en_a = 1; en_b = 0; mode_a = 1; mode_b = 1; tick;
    check("R8 A only links both", {14'h0, en_rb}, 16'h0003);
    push(1'b1, 19'h6B0B0); push(1'b0, 19'h0A0A0);
    en_b = 1; tick;
    check("R8 both set", {14'h0, en_rb}, 16'h0003);
    en_b = 0; tick;
    check("R9 B stays enabled", {14'h0, en_rb}, 16'h0003);
    expect_empty("R9 clearing B empties B", 1'b1, 1'b0);
    rd(1'b0, 1'b0, 1'b0, d); check("R9 A untouched by B clear", d, hi_of(1'b1, 1'b0, 19'h0A0A0));
    push(1'b1, 19'h12345);
    en_b = 1; tick; en_a = 0; tick;
    check("R8 B only", {14'h0, en_rb}, 16'h0002);
    rd(1'b0, 1'b0, 1'b0, d); check("R9/R7 A off bypass", d, {5'b0, live_a[18:8]});
    expect_entry("R9 B kept when A cleared", 1'b1, 19'h12345, 1'b0);
    en_a = 1; tick;
    expect_empty("R9 A emptied", 1'b0, 1'b0);
    en_b = 0; tick;
    push(1'b0, 19'h1F00F); push(1'b1, 19'h2E00E);
    en_a = 0; tick;
    check("R8 neither", {14'h0, en_rb}, 16'h0000);
    en_a = 1; tick;
    expect_empty("R9 linked clear A", 1'b0, 1'b0);
    expect_empty("R9 linked clear B", 1'b1, 1'b0);
  endtask

  task automatic t_por;
    push(1'b0, 19'h03030); push(1'b1, 19'h04040);
    rst_n = 0; tick; rst_n = 1; tick;
    expect_empty("R10 reset empties A", 1'b0, 1'b0);
    expect_empty("R10 reset empties B", 1'b1, 1'b0);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) tick;
    rst_n = 1; tick;
    t_reset();
    t_order();
    t_full();
    t_simul();
    t_mode();
    t_link();
    t_por();
    finish_run();
  end
endmodule